// File: doc/BRIEF.md
# Receive Packet Read-Out Formatter

This block stands between the byte stream of a packet receiver and a host that fetches 32-bit words. Incoming bytes go into a byte-wide FIFO. Each packet is closed by a byte marked as last. Once a complete packet is stored, the host pulls it out one word per read strobe. The block reshapes the framing on the way out. A programmable 0 to 31 byte zero pad goes in front of the packet data. Zero words are then appended until the whole transfer, counted from the first pad byte, fills a whole multiple of the selected boundary.

A single configuration write port loads every setting at once:

| Field | Bits (default parameters) |
|---|---|
| End boundary code | [1:0] |
| Lead offset | [6:2] |
| Word countdown | [18:7] |
| Discard command | [19] |

The same layout is returned on a read-back port. The countdown field there shows the remaining count, and the discard field shows the self-clearing command bit.

The word countdown decrements once for every word the host reads. When it runs out, it raises a sticky interrupt, which is cleared by a dedicated clear pulse. The discard command empties the FIFO and drops all stored packets.

Top module: `rx_readout_fmt`

## Requirements
- R1: The end boundary code selects the padding. Code 0 gives a 4-byte boundary, code 1 gives 16 bytes (4 words) and code 2 gives 32 bytes (8 words). The reserved code 3 behaves as code 0. Each packet transfer occupies the smallest whole number of boundaries that covers the lead offset plus the packet bytes.
- R2: Every lead pad byte, every unused byte lane after the last packet byte, and every appended end word reads as zero.
- R3: The end boundary code is sampled at the first read of a packet. Writing a new code while a packet is partly read changes only later packets.
- R4: Packet bytes fill word lanes little-endian (byte n of a word in bits 8n+7:8n). The first packet byte is placed after lead-offset bytes of zero.
- R5: The two low bits of the lead offset take a written value only while rx_en is low and the FIFO holds no byte. Otherwise those two bits keep their old value, and the read-back shows the old value.
- R6: The upper three bits of the lead offset accept writes at any time. A change applies from the next word read, including mid-packet while lead pad words are still being output.
- R7: The word countdown loses one for each word read while a complete packet is stored. The read that takes it from 1 to 0 sets the interrupt at the same clock edge.
- R8: A configuration write reloads the countdown and restarts it. Writing 0 disarms it, so later reads cause no interrupt and the count stays at 0.
- R9: The interrupt stays set until irq_clr is pulsed. A new set in the same cycle wins over the clear.
- R10: A write with the discard bit set drops all stored bytes and packets, so pkt_rdy falls at the next cycle. The discard bit reads back as 1 for the one cycle after the write, then as 0.
- R11: A read while no complete packet is stored returns zero and leaves the countdown unchanged.
- R12: pkt_rdy is high whenever at least one packet, including the one being read, is completely stored. It falls after the last word of the last stored packet is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver running |
| in_valid | input | 1 | Packet byte valid |
| in_byte | input | 8 | Packet byte |
| in_last | input | 1 | Marks the last byte of a packet |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration read-back |
| host_rd | input | 1 | Host word read strobe |
| rd_data | output | 32 | Word returned for the last read strobe |
| pkt_rdy | output | 1 | A complete packet is stored |
| irq_clr | input | 1 | Clears the interrupt |
| irq | output | 1 | Countdown-exhausted interrupt |

## Verification
The framing is tried with a table of packets that crosses every boundary code, including the reserved one, with lead offsets from 0 to 31 and with lengths that end on each byte lane. This separates errors in lane placement from errors in tail-word counting. The packets also wrap the FIFO pointers. Directed sequences then change the end code and the upper offset bits mid-packet, which distinguishes a design that samples at packet start from one that follows the live setting. They also attempt low offset writes while the receiver runs or holds data. Countdown sequences reload, disarm and exhaust the counter with reads on an empty FIFO in between, so a count decremented by empty reads or an interrupt raised by a disarmed counter is exposed.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;
   typedef enum logic [1:0] {PH_HEAD = 2'd0, PH_DATA = 2'd1, PH_TAIL = 2'd2} phase_t;

   // True when n words close a whole boundary for end code al
   function automatic logic blk_done(input logic [1:0] al, input logic [2:0] n);
      case (al)
         2'b01:   return (n[1:0] == 2'b00);
         2'b10:   return (n == 3'b000);
         default: return 1'b1;
      endcase
   endfunction
endpackage

// File: rtl/rxfmt_byte_fifo.sv
module rxfmt_byte_fifo #(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [7:0]       wr_byte,
   input  logic             wr_last,
   input  logic             pop,
   input  logic [2:0]       pop_cnt,
   input  logic             pkt_done,
   output logic [3:0][7:0]  peek_byte,
   output logic [3:0]       peek_last,
   output logic             pkt_rdy,
   output logic             empty
);
   logic [7:0]  mem_b [DEPTH];
   logic        mem_l [DEPTH];
   logic [AW:0] wr_ptr, rd_ptr, pkt_cnt;
   logic        full, do_wr;

   assign full  = ((wr_ptr - rd_ptr) == (AW+1)'(DEPTH));
   assign empty = (wr_ptr == rd_ptr);
   assign do_wr = wr_en && !full && !flush;
   assign pkt_rdy = (pkt_cnt != '0);

   for (genvar i = 0; i < 4; i++) begin : g_peek
      assign peek_byte[i] = mem_b[rd_ptr[AW-1:0] + AW'(i)];
      assign peek_last[i] = mem_l[rd_ptr[AW-1:0] + AW'(i)];
   end

   always_ff @(posedge clk) begin
      if (do_wr) begin
         mem_b[wr_ptr[AW-1:0]] <= wr_byte;
         mem_l[wr_ptr[AW-1:0]] <= wr_last;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         pkt_cnt <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (pop) rd_ptr <= rd_ptr + (AW+1)'(pop_cnt);
         pkt_cnt <= pkt_cnt + (AW+1)'(do_wr && wr_last) - (AW+1)'(pkt_done);
      end
   end

   assert_fill_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr - rd_ptr) <= (AW+1)'(DEPTH));
   assert_rdy_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_last && !full && !flush) |=> pkt_rdy);
endmodule

// File: rtl/rxfmt_word_build.sv
module rxfmt_word_build (
   input  logic [3:0][7:0] peek_byte,
   input  logic [3:0]      peek_last,
   input  logic [1:0]      start_lane,
   output logic [31:0]     word,
   output logic [2:0]      take,
   output logic            hit_last
);
   always_comb begin
      logic [2:0] k;
      logic       done;
      word = '0;
      k = '0;
      done = 1'b0;
      hit_last = 1'b0;
      for (int j = 0; j < 4; j++) begin
         if (j >= int'(start_lane) && !done) begin
            word[8*j +: 8] = peek_byte[k[1:0]];
            if (peek_last[k[1:0]]) begin
               done = 1'b1;
               hit_last = 1'b1;
            end
            k = k + 3'd1;
         end
      end
      take = k;
   end
endmodule

// File: rtl/rxfmt_dma_cnt.sv
module rxfmt_dma_cnt #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             irq
);
   logic hit_zero;
   assign hit_zero = !load && dec && (cnt == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         irq <= 1'b0;
      end else begin
         if (load) cnt <= load_val;
         else if (dec && cnt != '0) cnt <= cnt - 1'b1;
         if (hit_zero) irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
      end
   end

   assert_irq_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt == CNT_W'(1)) |=> irq);
   assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load && !irq) |=> !irq);
endmodule

// File: rtl/rx_readout_fmt.sv
module rx_readout_fmt
   import rxfmt_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int CNT_W      = 12,
   parameter int OFF_W      = 5,
   localparam int WOFF_W  = OFF_W - 2,
   localparam int CW      = (WOFF_W > 3) ? WOFF_W : 3,
   localparam int OFF_LSB = 2,
   localparam int CNT_LSB = OFF_LSB + OFF_W,
   localparam int DIS_BIT = CNT_LSB + CNT_W
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_en,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   input  logic        in_last,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        host_rd,
   output logic [31:0] rd_data,
   output logic        pkt_rdy,
   input  logic        irq_clr,
   output logic        irq
);
   if (FIFO_DEPTH < 8 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_chk_depth
      $error("FIFO_DEPTH must be a power of two of at least 8");
   end
   if (OFF_W < 3 || DIS_BIT > 31) begin : g_chk_fields
      $error("configuration fields do not fit the 32-bit word");
   end
   if (DIS_BIT < 31) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^cfg_wdata[31:DIS_BIT+1];
   end

   logic [1:0]       align_q, lat_align, eff_align;
   logic [OFF_W-1:0] off_q;
   logic             disc_q, flush, halted_empty;
   phase_t           phase;
   logic [CW-1:0]    wcnt, wnext;
   logic [3:0][7:0]  peek_byte;
   logic [3:0]       peek_last;
   logic             fifo_empty, in_head, word_ok, pop, hit_last, al_done, end_now;
   logic [2:0]       take;
   logic [31:0]      built, word_out;
   logic [CNT_W-1:0] cnt;

   assign flush        = cfg_we && cfg_wdata[DIS_BIT];
   assign halted_empty = !rx_en && fifo_empty;
   assign eff_align    = (phase == PH_HEAD && wcnt == '0) ? align_q : lat_align;
   assign in_head      = (phase == PH_HEAD) && (wcnt < CW'(off_q[OFF_W-1:2]));
   assign word_ok      = host_rd && pkt_rdy && !flush;
   assign pop          = word_ok && !in_head && (phase != PH_TAIL);
   assign word_out     = (in_head || phase == PH_TAIL) ? '0 : built;
   assign wnext        = wcnt + 1'b1;
   assign al_done      = blk_done(eff_align, wnext[2:0]);
   assign end_now      = word_ok && al_done &&
                         ((phase == PH_TAIL) || (!in_head && hit_last));

   rxfmt_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk, .rst_n, .flush,
      .wr_en(in_valid), .wr_byte(in_byte), .wr_last(in_last),
      .pop, .pop_cnt(take), .pkt_done(end_now),
      .peek_byte, .peek_last, .pkt_rdy, .empty(fifo_empty)
   );

   rxfmt_word_build u_build (
      .peek_byte, .peek_last,
      .start_lane((phase == PH_HEAD) ? off_q[1:0] : 2'b00),
      .word(built), .take, .hit_last
   );

   rxfmt_dma_cnt #(.CNT_W(CNT_W)) u_dma (
      .clk, .rst_n,
      .load(cfg_we), .load_val(cfg_wdata[CNT_LSB +: CNT_W]),
      .dec(word_ok), .irq_clr, .cnt, .irq
   );

   // configuration fields
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         align_q <= '0;
         off_q   <= '0;
         disc_q  <= 1'b0;
      end else begin
         disc_q <= flush;
         if (cfg_we) begin
            align_q <= cfg_wdata[1:0];
            off_q[OFF_W-1:2] <= cfg_wdata[OFF_LSB+2 +: WOFF_W];
            if (halted_empty) off_q[1:0] <= cfg_wdata[OFF_LSB +: 2];
         end
      end
   end

   // packet framing sequencer
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         phase     <= PH_HEAD;
         wcnt      <= '0;
         lat_align <= '0;
      end else if (word_ok) begin
         lat_align <= eff_align;
         if (end_now) begin
            phase <= PH_HEAD;
            wcnt  <= '0;
         end else begin
            wcnt <= wnext;
            if (phase != PH_TAIL && !in_head)
               phase <= hit_last ? PH_TAIL : PH_DATA;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else if (host_rd) rd_data <= word_ok ? word_out : '0;
   end

   always_comb begin
      cfg_rdata = '0;
      cfg_rdata[1:0] = align_q;
      cfg_rdata[OFF_LSB +: OFF_W] = off_q;
      cfg_rdata[CNT_LSB +: CNT_W] = cnt;
      cfg_rdata[DIS_BIT] = disc_q;
   end

   assert_empty_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !pkt_rdy) |=> rd_data == '0);
   assert_empty_no_dec_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !pkt_rdy && !cfg_we) |=> $stable(cnt));
   assert_lowoff_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en || !fifo_empty) |=> off_q[1:0] == $past(off_q[1:0]));
   assert_disc_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (disc_q && !cfg_we) |=> !disc_q);
   assert_flush_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !pkt_rdy);
   assert_tail_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && pkt_rdy && !flush && phase == PH_TAIL) |=> rd_data == '0);
endmodule

// File: tb/rx_readout_fmt_tb.sv
module rx_readout_fmt_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0, in_valid = 1'b0, in_last = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        cfg_we = 1'b0, host_rd = 1'b0, irq_clr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata, rd_data;
   logic        pkt_rdy, irq;
   int          errors = 0, checks = 0, cycles = 0;
   logic [31:0] w;

   always #10 clk = ~clk;

   rx_readout_fmt dut_i (
      .clk, .rst_n, .rx_en, .in_valid, .in_byte, .in_last,
      .cfg_we, .cfg_wdata, .cfg_rdata, .host_rd, .rd_data, .pkt_rdy,
      .irq_clr, .irq
   );

   // {align[1:0], offset[4:0], length[7:0], seed[7:0]}
   localparam logic [22:0] VEC [8] = '{
      {2'd0, 5'd0,  8'd8,  8'h10},
      {2'd0, 5'd3,  8'd5,  8'h40},
      {2'd1, 5'd0,  8'd5,  8'h60},
      {2'd1, 5'd6,  8'd13, 8'h80},
      {2'd2, 5'd1,  8'd1,  8'hA0},
      {2'd2, 5'd31, 8'd20, 8'hB0},
      {2'd3, 5'd2,  8'd7,  8'hC8},
      {2'd1, 5'd0,  8'd16, 8'hE0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] al, input logic [4:0] off,
                            input logic [11:0] cnt, input logic disc);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = {12'd0, disc, cnt, off, al};
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic push_pkt(input int len, input logic [7:0] seed);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_byte = seed + 8'(i);
         in_last = (i == len - 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last = 1'b0;
   endtask

   task automatic rd_word(output logic [31:0] d);
      @(negedge clk);
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = rd_data;
   endtask

   function automatic logic [31:0] exp_word(input int off, input int len,
                                            input logic [7:0] seed, input int idx);
      logic [31:0] r = '0;
      for (int l = 0; l < 4; l++) begin
         int p = idx * 4 + l;
         if (p >= off && p < off + len) r[8*l +: 8] = seed + 8'(p - off);
      end
      return r;
   endfunction

   function automatic int exp_words(input int al, input int off, input int len);
      int wds = (off + len + 3) / 4;
      int blk = (al == 1) ? 4 : (al == 2) ? 8 : 1;
      return ((wds + blk - 1) / blk) * blk;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R12 reset pkt_rdy", {31'd0, pkt_rdy}, 32'd0);
      chk("R9 reset irq", {31'd0, irq}, 32'd0);
      chk("R10 reset cfg_rdata", cfg_rdata, 32'd0);
      chk("R11 reset rd_data", rd_data, 32'd0);

      // table of framing vectors: R1 R2 R4 R12
      foreach (VEC[v]) begin
         int al = int'(VEC[v][22:21]);
         int off = int'(VEC[v][20:16]);
         int len = int'(VEC[v][15:8]);
         logic [7:0] seed = VEC[v][7:0];
         int n = exp_words(al, off, len);
         cfg_write(2'(al), 5'(off), 12'd0, 1'b0);
         push_pkt(len, seed);
         chk("R12 pkt_rdy after packet", {31'd0, pkt_rdy}, 32'd1);
         for (int i = 0; i < n; i++) begin
            rd_word(w);
            chk($sformatf("R1/R2/R4 vec%0d word%0d", v, i), w, exp_word(off, len, seed, i));
         end
         chk($sformatf("R1 vec%0d ends after %0d words", v, n), {31'd0, pkt_rdy}, 32'd0);
      end

      // R3: end code written mid-packet only affects later packets
      cfg_write(2'd0, 5'd0, 12'd0, 1'b0);
      push_pkt(6, 8'h20);
      rd_word(w);
      chk("R3 first word", w, 32'h23222120);
      cfg_write(2'd2, 5'd0, 12'd0, 1'b0);
      rd_word(w);
      chk("R3 second word", w, 32'h00002524);
      chk("R3 old code closes packet", {31'd0, pkt_rdy}, 32'd0);
      push_pkt(4, 8'h30);
      rd_word(w);
      chk("R3 new code data", w, 32'h33323130);
      for (int i = 1; i < 7; i++) rd_word(w);
      chk("R3 pad still pending", {31'd0, pkt_rdy}, 32'd1);
      rd_word(w);
      chk("R2 last pad zero", w, 32'd0);
      chk("R3 32-byte packet done", {31'd0, pkt_rdy}, 32'd0);

      // R5: low offset bits locked while running or holding data
      rx_en = 1'b1;
      cfg_write(2'd0, 5'd3, 12'd0, 1'b0);
      chk("R5 ignored while running", {27'd0, cfg_rdata[6:2]}, 32'd0);
      rx_en = 1'b0;
      push_pkt(1, 8'h5A);
      cfg_write(2'd0, 5'd3, 12'd0, 1'b0);
      chk("R5 ignored while data held", {27'd0, cfg_rdata[6:2]}, 32'd0);
      rd_word(w);
      chk("R5 packet unshifted", w, 32'h0000005A);
      cfg_write(2'd0, 5'd3, 12'd0, 1'b0);
      chk("R5 accepted when halted and empty", {27'd0, cfg_rdata[6:2]}, 32'd3);

      // R6: word offset changed mid-stream
      cfg_write(2'd0, 5'd8, 12'd0, 1'b0);
      rx_en = 1'b1;
      push_pkt(4, 8'h10);
      rd_word(w);
      chk("R6 lead pad word", w, 32'd0);
      cfg_write(2'd0, 5'd0, 12'd0, 1'b0);
      rd_word(w);
      chk("R6 data follows new offset", w, 32'h13121110);
      chk("R6 packet done", {31'd0, pkt_rdy}, 32'd0);
      rx_en = 1'b0;

      // R7 R11 R9: countdown and interrupt
      cfg_write(2'd0, 5'd0, 12'd3, 1'b0);
      push_pkt(8, 8'h01);
      rd_word(w);
      rd_word(w);
      chk("R7 count after two reads", {20'd0, cfg_rdata[18:7]}, 32'd1);
      chk("R7 no irq yet", {31'd0, irq}, 32'd0);
      rd_word(w);
      chk("R11 empty read zero", w, 32'd0);
      chk("R11 empty read no decrement", {20'd0, cfg_rdata[18:7]}, 32'd1);
      push_pkt(4, 8'h02);
      rd_word(w);
      chk("R7 count reaches zero", {20'd0, cfg_rdata[18:7]}, 32'd0);
      chk("R7 irq raised", {31'd0, irq}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R9 irq sticky", {31'd0, irq}, 32'd1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R9 irq cleared", {31'd0, irq}, 32'd0);

      // R8: reload restarts, zero disarms
      cfg_write(2'd0, 5'd0, 12'd2, 1'b0);
      push_pkt(12, 8'h70);
      rd_word(w);
      chk("R8 count 2 to 1", {20'd0, cfg_rdata[18:7]}, 32'd1);
      cfg_write(2'd0, 5'd0, 12'd3, 1'b0);
      rd_word(w);
      rd_word(w);
      chk("R8 restarted count", {20'd0, cfg_rdata[18:7]}, 32'd1);
      chk("R8 no irq after restart", {31'd0, irq}, 32'd0);
      cfg_write(2'd0, 5'd0, 12'd0, 1'b0);
      push_pkt(4, 8'h90);
      rd_word(w);
      chk("R8 disarmed data", w, 32'h93929190);
      chk("R8 disarmed no irq", {31'd0, irq}, 32'd0);
      chk("R8 disarmed count", {20'd0, cfg_rdata[18:7]}, 32'd0);

      // R10: discard
      push_pkt(9, 8'h44);
      chk("R10 packet stored", {31'd0, pkt_rdy}, 32'd1);
      cfg_write(2'd0, 5'd0, 12'd0, 1'b1);
      chk("R10 discard bit set", {31'd0, cfg_rdata[19]}, 32'd1);
      chk("R10 pkt_rdy dropped", {31'd0, pkt_rdy}, 32'd0);
      @(negedge clk);
      chk("R10 discard self-clears", {31'd0, cfg_rdata[19]}, 32'd0);
      rd_word(w);
      chk("R10 read after discard", w, 32'd0);
      push_pkt(4, 8'hD0);
      rd_word(w);
      chk("R10 fresh packet after discard", w, 32'hD3D2D1D0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule